// File: doc/BRIEF.md
# Opcode Exception Classifier

This block sorts a 16-bit instruction word into one of seven classes before execution starts. The classes are a normal instruction, an unimplemented line-A word, an unimplemented line-F word, a software trap, a breakpoint, a privilege violation and an illegal word. The outcome depends on the word itself, on a processor-generation selector and on the current supervisor state. The same encoding can therefore be legal on one generation and illegal on an earlier one. It can also be accepted in supervisor mode and rejected in user mode.

The caller presents a word with a one-cycle valid strobe. One clock later the block gives a one-hot class, an index field for traps and breakpoints, the exception vector number, and the major group for normal words, together with an output valid flag. Generation codes run from 0 (oldest) to 4 (newest). Codes above 4 behave as generation 4.

Top module: `opc_classifier`

## Requirements
- R1: After reset, outValid, classOut, indexOut, vectorOut and groupOut are all zero.
- R2: A word sampled with inValid high produces its result and outValid high on the next clock edge. A cycle with inValid low gives outValid low on the next edge and leaves classOut, indexOut, vectorOut and groupOut unchanged.
- R3: classOut is one-hot whenever outValid is high. The bit positions are normal 0, line-A 1, line-F 2, trap 3, breakpoint 4, privilege 5, illegal 6. When several rules match, the priority is illegal, then privilege, then trap/breakpoint, then line-A/line-F, then normal.
- R4: Any word with bits 15:12 equal to 0xA is line-A with vector 10.
- R5: A word with bits 15:12 equal to 0xF is line-F (vector 11) on generations 0 and 1. On generation 2 and later it is normal with group 15 when bits 11:9 are 0 (memory management) or 1 (floating point); otherwise it is line-F unless R11 or R12 claims it.
- R6: Word 0x4AFC is illegal with vector 4.
- R7: Words 0x4E40 to 0x4E4F are traps. The index is bits 3:0 and the vector is 32 plus the index.
- R8: Words 0x4848 to 0x484F are breakpoints. The index is bits 2:0 and the vector is 4.
- R9: Words 0x4E7A and 0x4E7B (control-register moves) are illegal on generation 0. On later generations they give privilege with vector 8 in user mode, and normal with group 4 in supervisor mode.
- R10: Words 0x4808 to 0x480F (long link) and 0x4C00 to 0x4C7F (long multiply/divide) are illegal on generations 0 and 1 and normal with group 4 from generation 2 on.
- R11: Line-F words with bits 11:8 equal to 4 or 5 (cache control) are claimed only on generations 3 and 4. There they give privilege with vector 8 in user mode and normal with group 15 in supervisor mode.
- R12: Words 0xF620 to 0xF627 (block move) are line-F on generations 0 and 1, illegal on generation 2, and normal with group 15 on generations 3 and 4.
- R13: Every other word is normal, with groupOut equal to bits 15:12, indexOut 0 and vectorOut 0. indexOut is 0 for every class except trap and breakpoint, and groupOut is 0 for every class except normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Strobe: sample the word this cycle |
| opcode | input | 16 | Instruction word to classify |
| genSel | input | 3 | Processor generation, 0 oldest, 4 newest |
| supervisor | input | 1 | 1 when the current privilege level is supervisor |
| outValid | output | 1 | Result registered from the previous strobe |
| classOut | output | 7 | One-hot class |
| indexOut | output | 4 | Trap or breakpoint index |
| vectorOut | output | 8 | Exception vector number, 0 for normal words |
| groupOut | output | 4 | Major group of a normal word |

## Verification
The assertions assume that opcode, genSel and supervisor are stable and known in every cycle where inValid is high. They make no assumption about these inputs in other cycles. The bench drives all three on the falling edge, so they are settled before each sampling edge. It also drives them only with defined values, including generation code 5, which checks the saturation to the newest generation. The sweeps cover the whole 0x48xx to 0x4Fxx range and the whole line-F space for every generation and both privilege levels. Pseudo-random words cover the remaining groups.

// File: rtl/opc_classifier_pkg.sv
package opc_classifier_pkg;

  localparam int OPC_W = 16;
  localparam int IDX_W = 4;
  localparam int VEC_W = 8;
  localparam int GRP_W = 4;
  localparam int CLS_W = 7;
  localparam int GEN_W = 3;
  localparam int NUM_GEN = 5;

  // one-hot bit positions of the class vector, low to high priority
  localparam int CL_NORMAL  = 0;
  localparam int CL_LINEA   = 1;
  localparam int CL_LINEF   = 2;
  localparam int CL_TRAP    = 3;
  localparam int CL_BKPT    = 4;
  localparam int CL_PRIV    = 5;
  localparam int CL_ILLEGAL = 6;

  localparam int ILLEGAL_VEC   = 4;
  localparam int BKPT_VEC      = 4;
  localparam int PRIV_VEC      = 8;
  localparam int LINEA_VEC     = 10;
  localparam int LINEF_VEC     = 11;
  localparam int TRAP_VEC_BASE = 32;

  // first generation that supports each feature
  localparam int GEN_CTRL_MOVE = 1;
  localparam int GEN_COPROC    = 2;
  localparam int GEN_LONG_OPS  = 2;
  localparam int GEN_CACHE     = 3;

  typedef struct packed {
    logic load;
  } ctrlStrobe_t;

  typedef struct packed {
    logic [CLS_W-1:0] cls;
    logic [IDX_W-1:0] idx;
    logic [VEC_W-1:0] vec;
    logic [GRP_W-1:0] grp;
  } classResult_t;

endpackage

// File: rtl/opc_class_decode.sv
module opc_class_decode
  import opc_classifier_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [GEN_W-1:0] genSel,
  input  logic             supervisor,
  output classResult_t     result
);

  localparam logic [GEN_W-1:0] TOP_GEN = GEN_W'(NUM_GEN - 1);

  logic [GEN_W-1:0] effGen;
  logic [3:0]       major;
  logic             hasCtrlMove, hasCoproc, hasLongOps, hasCache;
  logic             isDedIllegal, isCtrlMove, isLongLink, isLongArith;
  logic             isTrap, isBkpt, isLineFGrp, isCache, isBlockMove, isMmu, isFpu;
  logic             fClaimed;
  logic [CLS_W-1:0] hit;
  logic [CLS_W-1:0] cls;
  logic             seen;

  assign effGen = (genSel > TOP_GEN) ? TOP_GEN : genSel;
  assign major  = opcode[15:12];

  assign hasCtrlMove = effGen >= GEN_W'(GEN_CTRL_MOVE);
  assign hasCoproc   = effGen >= GEN_W'(GEN_COPROC);
  assign hasLongOps  = effGen >= GEN_W'(GEN_LONG_OPS);
  assign hasCache    = effGen >= GEN_W'(GEN_CACHE);

  assign isDedIllegal = opcode == 16'h4AFC;
  assign isCtrlMove   = opcode[15:1] == 15'h273D;
  assign isLongLink   = opcode[15:3] == 13'h0901;
  assign isLongArith  = opcode[15:7] == 9'h098;
  assign isTrap       = opcode[15:4] == 12'h4E4;
  assign isBkpt       = opcode[15:3] == 13'h0909;
  assign isLineFGrp   = major == 4'hF;
  assign isCache      = isLineFGrp && (opcode[11:8] == 4'h4 || opcode[11:8] == 4'h5);
  assign isBlockMove  = opcode[15:3] == 13'h1EC4;
  assign isMmu        = isLineFGrp && opcode[11:9] == 3'd0;
  assign isFpu        = isLineFGrp && opcode[11:9] == 3'd1;

  assign fClaimed = isMmu || isFpu || ((isCache || isBlockMove) && hasCache);

  always_comb begin
    hit = '0;
    hit[CL_NORMAL]  = 1'b1;
    hit[CL_LINEA]   = major == 4'hA;
    hit[CL_LINEF]   = isLineFGrp && (!hasCoproc || !fClaimed);
    hit[CL_TRAP]    = isTrap;
    hit[CL_BKPT]    = isBkpt;
    hit[CL_PRIV]    = !supervisor &&
                      ((isCtrlMove && hasCtrlMove) || (isCache && hasCache));
    hit[CL_ILLEGAL] = isDedIllegal ||
                      (isCtrlMove && !hasCtrlMove) ||
                      ((isLongLink || isLongArith) && !hasLongOps) ||
                      (isBlockMove && hasCoproc && !hasCache);
  end

  // priority pick: highest matching position wins
  always_comb begin
    seen = 1'b0;
    cls  = '0;
    for (int k = CLS_W - 1; k >= 0; k--) begin
      cls[k] = hit[k] && !seen;
      seen   = seen || hit[k];
    end
  end

  always_comb begin
    result     = '0;
    result.cls = cls;
    if (cls[CL_ILLEGAL]) begin
      result.vec = VEC_W'(ILLEGAL_VEC);
    end else if (cls[CL_PRIV]) begin
      result.vec = VEC_W'(PRIV_VEC);
    end else if (cls[CL_TRAP]) begin
      result.idx = opcode[3:0];
      result.vec = VEC_W'(TRAP_VEC_BASE) + VEC_W'(opcode[3:0]);
    end else if (cls[CL_BKPT]) begin
      result.idx = IDX_W'(opcode[2:0]);
      result.vec = VEC_W'(BKPT_VEC);
    end else if (cls[CL_LINEA]) begin
      result.vec = VEC_W'(LINEA_VEC);
    end else if (cls[CL_LINEF]) begin
      result.vec = VEC_W'(LINEF_VEC);
    end else begin
      result.grp = major;
    end
  end

endmodule

// File: rtl/opc_class_ctrl.sv
module opc_class_ctrl
  import opc_classifier_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output ctrlStrobe_t strobe,
  output logic        outValid
);

  assign strobe.load = inValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_valid_drops_r2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

// File: rtl/opc_class_datapath.sv
module opc_class_datapath
  import opc_classifier_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [OPC_W-1:0] opcode,
  input  logic [GEN_W-1:0] genSel,
  input  logic             supervisor,
  output logic [CLS_W-1:0] classOut,
  output logic [IDX_W-1:0] indexOut,
  output logic [VEC_W-1:0] vectorOut,
  output logic [GRP_W-1:0] groupOut
);

  classResult_t nextRes;
  classResult_t curRes;

  opc_class_decode u_decode (
    .opcode    (opcode),
    .genSel    (genSel),
    .supervisor(supervisor),
    .result    (nextRes)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            curRes <= '0;
    else if (strobe.load) curRes <= nextRes;
  end

  assign classOut  = curRes.cls;
  assign indexOut  = curRes.idx;
  assign vectorOut = curRes.vec;
  assign groupOut  = curRes.grp;

  p_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> $onehot(classOut));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(classOut) && $stable(indexOut) &&
                     $stable(vectorOut) && $stable(groupOut));
  p_linea_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load && opcode[15:12] == 4'hA |=> classOut[CL_LINEA] &&
                                             vectorOut == VEC_W'(LINEA_VEC));
  p_dedicated_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load && opcode == 16'h4AFC |=> classOut[CL_ILLEGAL] &&
                                          vectorOut == VEC_W'(ILLEGAL_VEC));
  p_trap_vec_r7: assert property (@(posedge clk) disable iff (!rstN)
    classOut[CL_TRAP] |-> vectorOut == VEC_W'(TRAP_VEC_BASE) + VEC_W'(indexOut));
  p_priv_vec_r9: assert property (@(posedge clk) disable iff (!rstN)
    classOut[CL_PRIV] |-> vectorOut == VEC_W'(PRIV_VEC) && indexOut == '0);
  p_group_only_normal_r13: assert property (@(posedge clk) disable iff (!rstN)
    !classOut[CL_NORMAL] |-> groupOut == '0);

endmodule

// File: rtl/opc_classifier.sv
module opc_classifier
  import opc_classifier_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [15:0] opcode,
  input  logic [2:0]  genSel,
  input  logic        supervisor,
  output logic        outValid,
  output logic [6:0]  classOut,
  output logic [3:0]  indexOut,
  output logic [7:0]  vectorOut,
  output logic [3:0]  groupOut
);

  ctrlStrobe_t strobe;

  opc_class_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  opc_class_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .opcode    (opcode),
    .genSel    (genSel),
    .supervisor(supervisor),
    .classOut  (classOut),
    .indexOut  (indexOut),
    .vectorOut (vectorOut),
    .groupOut  (groupOut)
  );

endmodule

// File: tb/tb_opc_classifier.sv
`timescale 1ns/1ps
module tb_opc_classifier;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] opcode = '0;
  logic [2:0]  genSel = '0;
  logic        supervisor = 1'b0;
  logic        outValid;
  logic [6:0]  classOut;
  logic [3:0]  indexOut;
  logic [7:0]  vectorOut;
  logic [3:0]  groupOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // expectation of the word currently in flight
  bit          pending = 0;
  logic [6:0]  eCls;
  logic [3:0]  eIdx;
  logic [7:0]  eVec;
  logic [3:0]  eGrp;
  string       eTag;
  logic [31:0] lcg = 32'h1234_5677;

  always #5 clk = ~clk;

  opc_classifier dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode),
    .genSel(genSel), .supervisor(supervisor), .outValid(outValid),
    .classOut(classOut), .indexOut(indexOut), .vectorOut(vectorOut),
    .groupOut(groupOut)
  );

  function automatic void model(input logic [15:0] op, input int g, input bit s,
                                output logic [6:0] c, output logic [3:0] i,
                                output logic [7:0] v, output logic [3:0] gr,
                                output string tag);
    int eg = (g > 4) ? 4 : g;
    bit ctrlMv = (op == 16'h4E7A) || (op == 16'h4E7B);
    bit lLink  = (op >= 16'h4808) && (op <= 16'h480F);
    bit lArith = (op >= 16'h4C00) && (op <= 16'h4C7F);
    bit bMove  = (op >= 16'hF620) && (op <= 16'hF627);
    bit cache  = (op[15:8] == 8'hF4) || (op[15:8] == 8'hF5);
    c = 7'b000_0001; i = 0; v = 0; gr = op[15:12]; tag = "R13";
    if (op == 16'h4AFC) begin
      c = 7'b100_0000; v = 4; gr = 0; tag = "R6";
    end else if (ctrlMv && eg == 0) begin
      c = 7'b100_0000; v = 4; gr = 0; tag = "R9";
    end else if ((lLink || lArith) && eg < 2) begin
      c = 7'b100_0000; v = 4; gr = 0; tag = "R10";
    end else if (bMove && eg == 2) begin
      c = 7'b100_0000; v = 4; gr = 0; tag = "R12";
    end else if (ctrlMv && !s) begin
      c = 7'b010_0000; v = 8; gr = 0; tag = "R9";
    end else if (cache && eg >= 3 && !s) begin
      c = 7'b010_0000; v = 8; gr = 0; tag = "R11";
    end else if (op >= 16'h4E40 && op <= 16'h4E4F) begin
      c = 7'b000_1000; i = op[3:0]; v = 8'd32 + op[3:0]; gr = 0; tag = "R7";
    end else if (op >= 16'h4848 && op <= 16'h484F) begin
      c = 7'b001_0000; i = {1'b0, op[2:0]}; v = 4; gr = 0; tag = "R8";
    end else if (op[15:12] == 4'hA) begin
      c = 7'b000_0010; v = 10; gr = 0; tag = "R4";
    end else if (op[15:12] == 4'hF) begin
      if (eg < 2) begin
        c = 7'b000_0100; v = 11; gr = 0; tag = bMove ? "R12" : "R5";
      end else if (op[11:9] <= 3'd1) begin
        tag = "R5";
      end else if (cache && eg >= 3) begin
        tag = "R11";
      end else if (bMove && eg >= 3) begin
        tag = "R12";
      end else begin
        c = 7'b000_0100; v = 11; gr = 0; tag = cache ? "R11" : "R5";
      end
    end else if (ctrlMv) begin
      tag = "R9";
    end else if (lLink || lArith) begin
      tag = "R10";
    end
  endfunction

  task automatic compare_pending();
    checks++;
    if (outValid !== 1'b1 || classOut !== eCls || indexOut !== eIdx ||
        vectorOut !== eVec || groupOut !== eGrp) begin
      errors++;
      $display("FAIL %s op=%h gen=%0d sup=%0b: got v=%b c=%b i=%h vec=%0d g=%h, exp v=1 c=%b i=%h vec=%0d g=%h",
               eTag, opcode, genSel, supervisor, outValid, classOut, indexOut,
               vectorOut, groupOut, eCls, eIdx, eVec, eGrp);
    end
    checks++;
    if ($countones(classOut) != 1) begin
      errors++;
      $display("FAIL R3 one-hot: got %b, exp one bit set (%b)", classOut, eCls);
    end
  endtask

  // drive at the falling edge; the word driven one falling edge earlier is compared first
  task automatic apply(input logic [15:0] op, input int g, input bit s);
    logic [6:0] c; logic [3:0] i; logic [7:0] v; logic [3:0] gr; string t;
    @(negedge clk);
    if (pending) compare_pending();
    model(op, g, s, c, i, v, gr, t);
    opcode = op; genSel = 3'(g); supervisor = s; inValid = 1'b1;
    eCls = c; eIdx = i; eVec = v; eGrp = gr; eTag = t; pending = 1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got no completion, exp end of run");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (outValid !== 0 || classOut !== 0 || indexOut !== 0 || vectorOut !== 0 || groupOut !== 0) begin
      errors++;
      $display("FAIL R1 reset: got v=%b c=%b i=%h vec=%0d g=%h, exp all zero",
               outValid, classOut, indexOut, vectorOut, groupOut);
    end
    rstN = 1'b1;

    for (int g = 0; g <= 5; g++) begin
      for (int s = 0; s <= 1; s++) begin
        for (int op = 16'h4800; op <= 16'h4FFF; op++) apply(16'(op), g, s[0]);
        for (int op = 16'hF000; op <= 16'hFFFF; op++) apply(16'(op), g, s[0]);
        for (int n = 0; n < 512; n++) begin
          lcg = lcg * 32'd1103515245 + 32'd12345;
          apply(lcg[30:15], g, s[0]);
        end
        apply(16'h4AFC, g, s[0]);
        apply(16'hA123, g, s[0]);
      end
    end

    // R2: idle cycle leaves the previous result in place
    apply(16'h4E45, 4, 1'b1);
    @(negedge clk);
    compare_pending();
    pending = 0;
    inValid = 1'b0;
    opcode = 16'hA000;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || classOut !== 7'b000_1000 || indexOut !== 4'h5 ||
        vectorOut !== 8'd37 || groupOut !== 4'h0) begin
      errors++;
      $display("FAIL R2 hold: got v=%b c=%b i=%h vec=%0d, exp v=0 c=0001000 i=5 vec=37",
               outValid, classOut, indexOut, vectorOut);
    end
    finish_run();
  end

endmodule